// File: doc/BRIEF.md
# RGB Strobe Switch Sequencer with Dead-Time Control

This block drives the three low-side switches of a common-anode RGB LED stage. It turns a 2-bit colour-select input into one-hot switch enables. It also picks the 10-bit current code that the LED current DAC needs for the colour that is lit.

On every change of selection, switches that must turn off do so at once. Switches that must turn on wait out a programmable dead time, so two LED paths are never briefly connected together. A switch that is already on, and that the new selection keeps on, stays on through the whole dead time.

A direct mode lets three register bits set the switch states instead of the select input. A rail-enable input holds every switch off while the display supply rails are down. The block also reports whether the lit switch is one that applies transient current limiting, together with the shared limit level.

Top module: `rgb_strobe_bbm`

## Requirements
- R1: With direct mode off and rails on, select value 0 turns all switches off and sets `dac_valid`=0 and `dac_code`=0. Value 1 turns on `sw_on[0]` (first switch) with `dac_code`=`code_sw4`. Value 2 turns on `sw_on[1]` with `code_sw5`. Value 3 turns on `sw_on[2]` with `code_sw6`. `dac_valid` is 1 exactly when one switch is on.
- R2: A new select value reaches the switches 3 clock edges after it is sampled, because of the two-flop synchroniser plus the output register. Switches to be turned off drop in that cycle. Switches to be turned on rise D cycles later, where D is the dead time of R4.
- R3: A switch that is on before a change, and that the new target keeps on, stays on in every cycle of the dead time.
- R4: D is 0 for dead-time code 0. For any other code c, D is ceil((333 + 111·(c−1)) / CLK_PERIOD_NS) cycles. The code is taken when the change is seen. If nothing turns on, or D is 0, the new state appears at once.
- R5: With `direct_mode`=1, `direct_sw[0]`, `direct_sw[1]` and `direct_sw[2]` set the targets of switches 0, 1 and 2. They act one edge after being driven, with the same dead-time rules.
- R6: With `rails_ok`=0, every switch is off from the next edge on, whatever the select and direct inputs are. When the rails return, the target switches turn on after D.
- R7: `lim_active` is 1 when a switch that is on has its bit set in `lim_en` (same bit order as `sw_on`). `lim_level` then equals `lim_code`; otherwise it is 0.
- R8: A target change during a running dead time restarts the sequence from the current switch state. The pending switches never turn on, and the new ones turn on D cycles after the second change.
- R9: After reset, all switches are off, `dac_valid`=0, `dac_code`=0, `lim_active`=0 and `lim_level`=0.
- R10: In direct mode with two or more switches on, `dac_valid`=0 and `dac_code`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_async | input | 2 | Colour select, asynchronous |
| rails_ok | input | 1 | Supply rails up; 0 holds all switches off |
| direct_mode | input | 1 | Switches follow `direct_sw` |
| direct_sw | input | 3 | Direct switch targets, bit i = switch i |
| code_sw4 | input | DAC_W | Current code for switch 0 |
| code_sw5 | input | DAC_W | Current code for switch 1 |
| code_sw6 | input | DAC_W | Current code for switch 2 |
| bbm_code | input | 8 | Dead-time code |
| lim_en | input | 3 | Transient-limit enable per switch |
| lim_code | input | LIM_W | Shared transient-limit level |
| sw_on | output | 3 | Switch enables |
| dac_code | output | DAC_W | Selected current code |
| dac_valid | output | 1 | A single switch is on |
| lim_active | output | 1 | A lit switch uses transient limiting |
| lim_level | output | LIM_W | Limit level when active, else 0 |

## Verification
The bench builds the block with CLK_PERIOD_NS set to 50 while keeping the real 200 MHz clock. This shrinks the longest dead time to 571 cycles, so the bench can sweep all 256 dead-time codes and compare each measured gap against the arithmetic formula. With that setting it also runs all sixteen select-to-select transitions at two dead times. The direct-mode part covers overlap cases where one switch stays on, plus every combination of limit enables.

// File: rtl/strobe_pkg.sv
package strobe_pkg;

  localparam int BBM_CODE_W = 8;
  localparam int NUM_SW     = 3;

  typedef enum logic [1:0] {
    SEL_OFF = 2'd0,
    SEL_SW0 = 2'd1,
    SEL_SW1 = 2'd2,
    SEL_SW2 = 2'd3
  } colour_sel_e;

  // Dead time in ns: 0 for code 0, else 222 + 111 per code step.
  function automatic int unsigned deadtime_ns(input logic [BBM_CODE_W-1:0] code);
    int unsigned c;
    c = int'(code);
    return (c == 0) ? 0 : (222 + 111 * c);
  endfunction

  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned period);
    return (ns + period - 1) / period;
  endfunction

  function automatic logic [NUM_SW-1:0] decode_sel(input colour_sel_e sel);
    case (sel)
      SEL_SW0: return 3'b001;
      SEL_SW1: return 3'b010;
      SEL_SW2: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      d_sync <= '0;
    end else begin
      stage1 <= d_async;
      d_sync <= stage1;
    end
  end
endmodule

// File: rtl/strobe_deadtime.sv
module strobe_deadtime
  import strobe_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 5,
  parameter int CNT_W         = 13
) (
  input  logic [BBM_CODE_W-1:0] code,
  output logic [CNT_W-1:0]      cycles
);
  always_comb begin
    cycles = CNT_W'(ns_to_cycles(deadtime_ns(code), CLK_PERIOD_NS));
  end
endmodule

// File: rtl/strobe_switch_seq.sv
module strobe_switch_seq #(
  parameter int NSW   = 3,
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSW-1:0]   target,
  input  logic [CNT_W-1:0] load_cycles,
  output logic [NSW-1:0]   sw_next,
  output logic [NSW-1:0]   sw_on
);
  logic [NSW-1:0]   tgt_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NSW-1:0]   closing;
  logic             tgt_chg;
  logic             dly_zero;

  assign tgt_chg  = (target != tgt_q);
  assign closing  = target & ~sw_on;
  assign dly_zero = (load_cycles == '0);

  always_comb begin
    sw_next = sw_on;
    cnt_d   = cnt_q;
    if (tgt_chg) begin
      if (closing == '0 || dly_zero) begin
        sw_next = target;
        cnt_d   = '0;
      end else begin
        sw_next = sw_on & target;
        cnt_d   = load_cycles;
      end
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) sw_next = tgt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
      sw_on <= '0;
      cnt_q <= '0;
    end else begin
      tgt_q <= target;
      sw_on <= sw_next;
      cnt_q <= cnt_d;
    end
  end

  // R2: a cycle that turns a switch on turns none off, unless the dead time was zero
  a_r2_break_before_make: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_on & ~$past(sw_on)) != '0) |-> ((($past(sw_on) & ~sw_on) == '0) || $past(dly_zero)));

  // R3: a switch on before and still wanted is never dropped
  a_r3_keep_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(sw_on) & tgt_q & ~sw_on) == '0));

  // R4: the dead-time counter steps down by one while the target is steady
  a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !tgt_chg) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/rgb_strobe_bbm.sv
module rgb_strobe_bbm
  import strobe_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 5,
  parameter int DAC_W         = 10,
  parameter int LIM_W         = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            sel_async,
  input  logic                  rails_ok,
  input  logic                  direct_mode,
  input  logic [NUM_SW-1:0]     direct_sw,
  input  logic [DAC_W-1:0]      code_sw4,
  input  logic [DAC_W-1:0]      code_sw5,
  input  logic [DAC_W-1:0]      code_sw6,
  input  logic [BBM_CODE_W-1:0] bbm_code,
  input  logic [NUM_SW-1:0]     lim_en,
  input  logic [LIM_W-1:0]      lim_code,
  output logic [NUM_SW-1:0]     sw_on,
  output logic [DAC_W-1:0]      dac_code,
  output logic                  dac_valid,
  output logic                  lim_active,
  output logic [LIM_W-1:0]      lim_level
);
  localparam int MAX_CYC = ns_to_cycles(deadtime_ns({BBM_CODE_W{1'b1}}), CLK_PERIOD_NS);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [1:0]        sel_s;
  logic [NUM_SW-1:0] target;
  logic [NUM_SW-1:0] sw_next;
  logic [CNT_W-1:0]  load_cycles;
  logic [DAC_W-1:0]  codes [NUM_SW];
  logic [DAC_W-1:0]  dac_d;
  logic              valid_d;
  logic              lim_d;

  strobe_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(sel_async), .d_sync(sel_s)
  );

  always_comb begin
    if (!rails_ok)        target = '0;
    else if (direct_mode) target = direct_sw;
    else                  target = decode_sel(colour_sel_e'(sel_s));
  end

  strobe_deadtime #(.CLK_PERIOD_NS(CLK_PERIOD_NS), .CNT_W(CNT_W)) u_dt (
    .code(bbm_code), .cycles(load_cycles)
  );

  strobe_switch_seq #(.NSW(NUM_SW), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .target(target), .load_cycles(load_cycles),
    .sw_next(sw_next), .sw_on(sw_on)
  );

  assign codes[0] = code_sw4;
  assign codes[1] = code_sw5;
  assign codes[2] = code_sw6;

  always_comb begin
    dac_d   = '0;
    valid_d = 1'b0;
    for (int i = 0; i < NUM_SW; i++) begin
      if (sw_next == NUM_SW'(1 << i)) begin
        dac_d   = codes[i];
        valid_d = 1'b1;
      end
    end
    lim_d = (sw_next & lim_en) != '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code   <= '0;
      dac_valid  <= 1'b0;
      lim_active <= 1'b0;
      lim_level  <= '0;
    end else begin
      dac_code   <= dac_d;
      dac_valid  <= valid_d;
      lim_active <= lim_d;
      lim_level  <= lim_d ? lim_code : '0;
    end
  end

  // R6: rails down forces every switch off by the next edge
  a_r6_rails_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rails_ok |=> (sw_on == '0));

  // R1: outside direct mode at most one switch is on
  a_r1_single_switch: assert property (@(posedge clk) disable iff (!rst_n)
    !direct_mode |=> $onehot0(sw_on));

  // R1: no DAC code is presented when none is selected
  a_r1_dac_none: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_valid |-> (dac_code == '0));

  // R7: limiting is reported only with an enabled switch on
  a_r7_lim_source: assert property (@(posedge clk) disable iff (!rst_n)
    lim_active |-> ((sw_on & $past(lim_en)) != '0));
endmodule

// File: tb/rgb_strobe_bbm_test.sv
`timescale 1ns/100ps
module rgb_strobe_bbm_test;
  localparam int PERIOD_PARAM = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel_async = 2'd0;
  logic       rails_ok = 1'b0;
  logic       direct_mode = 1'b0;
  logic [2:0] direct_sw = 3'b000;
  logic [9:0] code_sw4 = 10'h029, code_sw5 = 10'h2AA, code_sw6 = 10'h3FF;
  logic [7:0] bbm_code = 8'd0;
  logic [2:0] lim_en = 3'b001;
  logic [3:0] lim_code = 4'hA;
  logic [2:0] sw_on;
  logic [9:0] dac_code;
  logic       dac_valid, lim_active;
  logic [3:0] lim_level;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rgb_strobe_bbm #(.CLK_PERIOD_NS(PERIOD_PARAM)) uut (
    .clk(clk), .rst_n(rst_n), .sel_async(sel_async), .rails_ok(rails_ok),
    .direct_mode(direct_mode), .direct_sw(direct_sw), .code_sw4(code_sw4),
    .code_sw5(code_sw5), .code_sw6(code_sw6), .bbm_code(bbm_code),
    .lim_en(lim_en), .lim_code(lim_code), .sw_on(sw_on), .dac_code(dac_code),
    .dac_valid(dac_valid), .lim_active(lim_active), .lim_level(lim_level)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int dead_cycles(input int c);
    int ns;
    if (c == 0) return 0;
    ns = 333 + 111 * (c - 1);
    return ns / PERIOD_PARAM + ((ns % PERIOD_PARAM) != 0 ? 1 : 0);
  endfunction

  function automatic logic [2:0] sel_to_sw(input logic [1:0] s);
    return (s == 2'd0) ? 3'b000 : 3'(1 << (s - 1));
  endfunction

  function automatic int exp_dac(input logic [2:0] s);
    if (s == 3'b001) return int'(code_sw4);
    if (s == 3'b010) return int'(code_sw5);
    if (s == 3'b100) return int'(code_sw6);
    return 0;
  endfunction

  // Inputs were driven at the current negedge; lat = negedges until the first effect.
  task automatic expect_seq(input int lat, input logic [2:0] from, input logic [2:0] to,
                            input int d, input string req);
    logic [2:0] mid;
    int t;
    mid = from & to;
    t = (((to & ~from) != 3'b000) && d > 0) ? d : 0;
    repeat (lat - 1) @(negedge clk);
    for (int i = 0; i < t; i++) begin
      @(negedge clk);
      chk(req, int'(sw_on), int'(mid));
    end
    @(negedge clk);
    chk(req, int'(sw_on), int'(to));
    chk({req, " dac"}, int'(dac_code), exp_dac(to));
    chk({req, " valid"}, int'(dac_valid), int'($onehot(to)));
  endtask

  task automatic go_sel(input logic [1:0] s, input string req);
    logic [2:0] from;
    from = sw_on;
    sel_async = s;
    expect_seq(3, from, sel_to_sw(s), dead_cycles(int'(bbm_code)), req);
  endtask

  task automatic go_dir(input logic [2:0] v, input string req);
    logic [2:0] from;
    from = sw_on;
    direct_mode = 1'b1;
    direct_sw = v;
    expect_seq(1, from, v, dead_cycles(int'(bbm_code)), req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    chk("R9 sw", int'(sw_on), 0);
    chk("R9 valid", int'(dac_valid), 0);
    chk("R9 dac", int'(dac_code), 0);
    chk("R9 lim", int'(lim_active), 0);
    chk("R9 level", int'(lim_level), 0);
    rst_n = 1'b1;
    rails_ok = 1'b1;
    repeat (4) @(negedge clk);

    // R1, R2: all select transitions at two dead times
    for (int b = 0; b < 2; b++) begin
      bbm_code = (b == 0) ? 8'd0 : 8'd3;
      for (int a = 0; a < 4; a++) begin
        for (int c = 0; c < 4; c++) begin
          go_sel(2'(a), "R1 R2 from");
          go_sel(2'(c), "R1 R2 to");
        end
      end
    end

    // R4: every dead-time code measured on a switch change
    for (int c = 0; c < 256; c++) begin
      bbm_code = 8'(c);
      go_sel(((c % 2) == 0) ? 2'd1 : 2'd2, "R4 prep");
      go_sel(((c % 2) == 0) ? 2'd2 : 2'd1, "R4 dead time");
    end

    // R8: change during the dead time restarts the wait
    bbm_code = 8'd10;
    go_sel(2'd1, "R8 prep");
    sel_async = 2'd2;
    repeat (3) @(negedge clk);
    chk("R8 opened", int'(sw_on), 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R8 waiting", int'(sw_on), 0);
    end
    go_sel(2'd3, "R8 restart");

    // R5, R3, R10: direct mode with overlap
    go_dir(3'b001, "R5 direct");
    go_dir(3'b011, "R3 R10 keep sw0");
    chk("R10 valid", int'(dac_valid), 0);
    go_dir(3'b110, "R3 keep sw1");
    go_dir(3'b111, "R5 R10 all");
    go_dir(3'b010, "R5 drop");

    // R6: rails off overrides everything
    rails_ok = 1'b0;
    expect_seq(1, sw_on, 3'b000, 0, "R6 off");
    for (int i = 0; i < 6; i++) begin
      direct_sw = 3'(i + 1);
      sel_async = 2'(i);
      direct_mode = i[0];
      @(negedge clk);
      chk("R6 held", int'(sw_on), 0);
    end
    repeat (3) @(negedge clk);
    chk("R6 held", int'(sw_on), 0);
    direct_mode = 1'b1;
    direct_sw = 3'b101;
    rails_ok = 1'b1;
    expect_seq(1, 3'b000, 3'b101, dead_cycles(10), "R6 return");

    // R7: limit enable combinations
    bbm_code = 8'd0;
    for (int e = 0; e < 8; e++) begin
      for (int s = 0; s < 3; s++) begin
        lim_en = 3'(e);
        direct_sw = 3'(1 << s);
        repeat (2) @(negedge clk);
        chk("R7 active", int'(lim_active), int'(e[s]));
        chk("R7 level", int'(lim_level), e[s] ? int'(lim_code) : 0);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule